// File: doc/BRIEF.md
# Instruction Fetch Cache with Lookup While Disabled

The block is a small read-only cache placed between an instruction fetch port and a word-wide memory read port. A control-register write supplies the enable: only bit 12 of the written word matters. While the cache is enabled, a cacheable fetch that misses loads the whole 32-byte line (eight words) from memory and then returns the requested word. Later fetches to that line are answered from the cache.

Turning the enable off does not hide the cache. Every cacheable fetch is still looked up, and a hit still returns the stored word. What stops is allocation: a miss becomes a single-word memory read that leaves the cache unchanged. Contents that may be stale are removed only by the flush input, or by reset, which also clears the enable. The cache is direct-mapped, and the number of sets is a parameter.

A fetch request is accepted only while `fetch_gnt_o` is high. Its answer arrives on `fetch_rvalid_o`/`fetch_rdata_o`. The memory side keeps `mem_req_o` and `mem_addr_o` steady until `mem_rvalid_i` returns the word for that address.

Top module: `ifetch_cache`

## Requirements
- R1: After reset the enable is clear and no line is valid. `fetch_gnt_o` is 1, and `fetch_rvalid_o` and `mem_req_o` are 0. A reset applied during operation clears the enable again, so the next cacheable fetch makes exactly one memory read.
- R2: A control write (`ctrl_we_i`=1) sets the enable to `ctrl_wdata_i[12]`. Every other bit of the written word has no effect.
- R3: When enabled, a cacheable fetch that misses reads eight words at the line base plus 0, 4, ... 28, in ascending order. It then marks the line valid and returns the requested word.
- R4: A cacheable fetch that hits raises `fetch_rvalid_o` in the cycle after acceptance, with the stored word, and makes no memory read.
- R5: When disabled, a cacheable fetch that hits still returns the stored word, even when memory now holds different data. It makes no memory read.
- R6: When disabled, a cacheable fetch that misses makes exactly one memory read at the fetch address, returns that word and allocates nothing.
- R7: A fetch with `fetch_cacheable_i`=0 always makes one memory read at its address and allocates nothing, even if its line is present.
- R8: A flush pulse invalidates every line, so the next cacheable fetch to any previously loaded line misses.
- R9: A flush during a line fill lets the fill finish and return the correct word, but the line stays invalid.
- R10: A flush in the same cycle as an accepted fetch makes that fetch a miss.
- R11: One fetch is served at a time. `fetch_gnt_o` is 0 while a memory read is outstanding, and `mem_addr_o` is held until `mem_rvalid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | CTRL_W (32) | Control word; bit 12 is the enable |
| flush_i | input | 1 | Invalidate all lines |
| fetch_req_i | input | 1 | Fetch request |
| fetch_addr_i | input | AW (32) | Fetch byte address, word aligned |
| fetch_cacheable_i | input | 1 | Fetch may be cached |
| fetch_gnt_o | output | 1 | Request accepted this cycle |
| fetch_rvalid_o | output | 1 | Fetch data valid |
| fetch_rdata_o | output | DW (32) | Fetch data |
| mem_req_o | output | 1 | Memory read outstanding |
| mem_addr_o | output | AW (32) | Memory word address |
| mem_rvalid_i | input | 1 | Memory data returned |
| mem_rdata_i | input | DW (32) | Memory data |

## Verification
Flush can coincide with two other actions: a lookup being accepted, and a line fill in progress. The bench provokes the first by driving `flush_i` and `fetch_req_i` in the same cycle on a line known to be valid. The second is provoked by pulsing `flush_i` after the third beat of a fill. In each case the result is judged at the ports: the word returned must be correct, and the number of memory reads on the following fetch to that line must match. That count is eight when the line was left invalid and zero when it was kept.

// File: rtl/ic_pkg.sv
package ic_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PASS = 2'd2
  } ic_state_e;

  localparam int unsigned CTRL_EN_BIT = 12;
  localparam int unsigned BYTE_OFS_W  = 2;
endpackage

// File: rtl/ic_tag_store.sv
module ic_tag_store #(
  parameter int unsigned SETS  = 16,
  parameter int unsigned TAG_W = 23
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic [$clog2(SETS)-1:0]   rd_idx_i,
  output logic                      rd_valid_o,
  output logic [TAG_W-1:0]          rd_tag_o,
  input  logic                      wr_en_i,
  input  logic [$clog2(SETS)-1:0]   wr_idx_i,
  input  logic [TAG_W-1:0]          wr_tag_i,
  output logic [SETS-1:0]           valid_vec_o
);
  localparam int unsigned IDX_W = $clog2(SETS);

  logic             valid_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[s] <= 1'b0;
        tag_q[s]   <= '0;
      end else if (flush_i) begin
        valid_q[s] <= 1'b0;  // flush beats a concurrent allocation
      end else if (wr_en_i && (wr_idx_i == IDX_W'(s))) begin
        valid_q[s] <= 1'b1;
        tag_q[s]   <= wr_tag_i;
      end
    end
    assign valid_vec_o[s] = valid_q[s];
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
endmodule

// File: rtl/ic_data_store.sv
module ic_data_store #(
  parameter int unsigned SETS       = 16,
  parameter int unsigned LINE_WORDS = 8,
  parameter int unsigned DW         = 32
) (
  input  logic                          clk_i,
  input  logic                          wr_en_i,
  input  logic [$clog2(SETS)-1:0]       wr_idx_i,
  input  logic [$clog2(LINE_WORDS)-1:0] wr_ofs_i,
  input  logic [DW-1:0]                 wr_data_i,
  input  logic [$clog2(SETS)-1:0]       rd_idx_i,
  input  logic [$clog2(LINE_WORDS)-1:0] rd_ofs_i,
  output logic [DW-1:0]                 rd_data_o
);
  localparam int unsigned DEPTH = SETS * LINE_WORDS;

  logic [DW-1:0] word_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) word_q[{wr_idx_i, wr_ofs_i}] <= wr_data_i;
  end

  assign rd_data_o = word_q[{rd_idx_i, rd_ofs_i}];
endmodule

// File: rtl/ic_fill_ctrl.sv
module ic_fill_ctrl
  import ic_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned DW         = 32,
  parameter int unsigned LINE_WORDS = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          en_i,
  input  logic                          flush_i,
  input  logic                          fetch_req_i,
  input  logic [AW-1:0]                 fetch_addr_i,
  input  logic                          fetch_cacheable_i,
  output logic                          fetch_gnt_o,
  output logic                          fetch_rvalid_o,
  output logic [DW-1:0]                 fetch_rdata_o,
  input  logic                          lookup_hit_i,
  input  logic [DW-1:0]                 hit_data_i,
  output logic                          mem_req_o,
  output logic [AW-1:0]                 mem_addr_o,
  input  logic                          mem_rvalid_i,
  input  logic [DW-1:0]                 mem_rdata_i,
  output logic                          tag_we_o,
  output logic                          data_we_o,
  output logic [$clog2(LINE_WORDS)-1:0] data_ofs_o,
  output logic [AW-1:0]                 line_addr_o,
  output logic                          filling_o
);
  localparam int unsigned OFS_W = $clog2(LINE_WORDS);
  localparam int unsigned LB    = OFS_W + BYTE_OFS_W;

  ic_state_e       state_q;
  logic [AW-1:0]   addr_q;
  logic [OFS_W-1:0] beat_q;
  logic            kill_q;
  logic            rvalid_q;
  logic [DW-1:0]   rdata_q;
  logic [DW-1:0]   hold_q;

  logic accept, use_hit, start_fill, start_pass, beat_ok, last_beat, want_beat;

  assign accept     = (state_q == ST_IDLE) && fetch_req_i;
  assign use_hit    = accept && fetch_cacheable_i && lookup_hit_i && !flush_i;
  assign start_fill = accept && fetch_cacheable_i && !use_hit && en_i;
  assign start_pass = accept && !use_hit && !start_fill;
  assign beat_ok    = (state_q == ST_FILL) && mem_rvalid_i;
  assign last_beat  = (beat_q == OFS_W'(LINE_WORDS - 1));
  assign want_beat  = (beat_q == addr_q[LB-1:BYTE_OFS_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      beat_q   <= '0;
      kill_q   <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      hold_q   <= '0;
    end else begin
      rvalid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (use_hit) begin
            rvalid_q <= 1'b1;
            rdata_q  <= hit_data_i;
          end else if (start_fill) begin
            state_q <= ST_FILL;
            addr_q  <= fetch_addr_i;
            beat_q  <= '0;
            kill_q  <= 1'b0;
          end else if (start_pass) begin
            state_q <= ST_PASS;
            addr_q  <= fetch_addr_i;
          end
        end
        ST_FILL: begin
          if (flush_i) kill_q <= 1'b1;
          if (mem_rvalid_i) begin
            if (want_beat) hold_q <= mem_rdata_i;
            beat_q <= beat_q + OFS_W'(1);
            if (last_beat) begin
              state_q  <= ST_IDLE;
              rvalid_q <= 1'b1;
              rdata_q  <= want_beat ? mem_rdata_i : hold_q;
            end
          end
        end
        ST_PASS: begin
          if (mem_rvalid_i) begin
            state_q  <= ST_IDLE;
            rvalid_q <= 1'b1;
            rdata_q  <= mem_rdata_i;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fetch_gnt_o    = (state_q == ST_IDLE);
  assign fetch_rvalid_o = rvalid_q;
  assign fetch_rdata_o  = rdata_q;
  assign mem_req_o      = (state_q == ST_FILL) || (state_q == ST_PASS);
  assign mem_addr_o     = (state_q == ST_FILL)
                          ? {addr_q[AW-1:LB], beat_q, {BYTE_OFS_W{1'b0}}}
                          : addr_q;
  // a flush seen anywhere in the fill keeps the line invalid
  assign tag_we_o       = beat_ok && last_beat && !kill_q && !flush_i;
  assign data_we_o      = beat_ok;
  assign data_ofs_o     = beat_q;
  assign line_addr_o    = addr_q;
  assign filling_o      = (state_q == ST_FILL);
endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache
  import ic_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned DW         = 32,
  parameter int unsigned CTRL_W     = 32,
  parameter int unsigned SETS       = 16,
  parameter int unsigned LINE_WORDS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              flush_i,
  input  logic              fetch_req_i,
  input  logic [AW-1:0]     fetch_addr_i,
  input  logic              fetch_cacheable_i,
  output logic              fetch_gnt_o,
  output logic              fetch_rvalid_o,
  output logic [DW-1:0]     fetch_rdata_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DW-1:0]     mem_rdata_i
);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned OFS_W = $clog2(LINE_WORDS);
  localparam int unsigned LB    = OFS_W + BYTE_OFS_W;
  localparam int unsigned TAG_W = AW - LB - IDX_W;

  logic en_q;
  logic unused_ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= 1'b0;
    else if (ctrl_we_i) en_q <= ctrl_wdata_i[CTRL_EN_BIT];
  end
  assign unused_ctrl = ^ctrl_wdata_i;

  logic [IDX_W-1:0] rd_idx;
  logic [TAG_W-1:0] rd_tag_want, rd_tag;
  logic             rd_valid, lookup_hit;
  logic [DW-1:0]    hit_data;
  logic             tag_we, data_we, fill_busy;
  logic [OFS_W-1:0] data_ofs;
  logic [AW-1:0]    line_addr;
  logic [SETS-1:0]  valid_vec;

  assign rd_idx      = fetch_addr_i[LB+IDX_W-1:LB];
  assign rd_tag_want = fetch_addr_i[AW-1:LB+IDX_W];
  assign lookup_hit  = rd_valid && (rd_tag == rd_tag_want);

  ic_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .rd_idx_i   (rd_idx),
    .rd_valid_o (rd_valid),
    .rd_tag_o   (rd_tag),
    .wr_en_i    (tag_we),
    .wr_idx_i   (line_addr[LB+IDX_W-1:LB]),
    .wr_tag_i   (line_addr[AW-1:LB+IDX_W]),
    .valid_vec_o(valid_vec)
  );

  ic_data_store #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .DW(DW)) u_data (
    .clk_i    (clk_i),
    .wr_en_i  (data_we),
    .wr_idx_i (line_addr[LB+IDX_W-1:LB]),
    .wr_ofs_i (data_ofs),
    .wr_data_i(mem_rdata_i),
    .rd_idx_i (rd_idx),
    .rd_ofs_i (fetch_addr_i[LB-1:BYTE_OFS_W]),
    .rd_data_o(hit_data)
  );

  ic_fill_ctrl #(.AW(AW), .DW(DW), .LINE_WORDS(LINE_WORDS)) u_ctrl (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .en_i             (en_q),
    .flush_i          (flush_i),
    .fetch_req_i      (fetch_req_i),
    .fetch_addr_i     (fetch_addr_i),
    .fetch_cacheable_i(fetch_cacheable_i),
    .fetch_gnt_o      (fetch_gnt_o),
    .fetch_rvalid_o   (fetch_rvalid_o),
    .fetch_rdata_o    (fetch_rdata_o),
    .lookup_hit_i     (lookup_hit),
    .hit_data_i       (hit_data),
    .mem_req_o        (mem_req_o),
    .mem_addr_o       (mem_addr_o),
    .mem_rvalid_i     (mem_rvalid_i),
    .mem_rdata_i      (mem_rdata_i),
    .tag_we_o         (tag_we),
    .data_we_o        (data_we),
    .data_ofs_o       (data_ofs),
    .line_addr_o      (line_addr),
    .filling_o        (fill_busy)
  );
endmodule

// File: rtl/ic_checks.sv
module ic_checks #(
  parameter int unsigned AW         = 32,
  parameter int unsigned SETS       = 16,
  parameter int unsigned LINE_WORDS = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            flush_i,
  input logic            fetch_req_i,
  input logic            fetch_gnt_o,
  input logic            fetch_rvalid_o,
  input logic            mem_req_o,
  input logic [AW-1:0]   mem_addr_o,
  input logic            mem_rvalid_i,
  input logic            fill_busy_i,
  input logic [SETS-1:0] valid_vec_i
);
  localparam int unsigned LB = $clog2(LINE_WORDS) + 2;

  a_r11_busy_no_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !fetch_gnt_o);

  a_r11_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  a_r4_accept_progress: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_i && fetch_gnt_o) |=> (fetch_rvalid_o || mem_req_o));

  a_r8_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_vec_i == '0));

  a_r3_beat_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_busy_i && mem_rvalid_i && (mem_addr_o[LB-1:2] != '1))
      |=> (mem_addr_o == $past(mem_addr_o) + AW'(4)));
endmodule

bind ifetch_cache ic_checks #(.AW(AW), .SETS(SETS), .LINE_WORDS(LINE_WORDS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .flush_i       (flush_i),
  .fetch_req_i   (fetch_req_i),
  .fetch_gnt_o   (fetch_gnt_o),
  .fetch_rvalid_o(fetch_rvalid_o),
  .mem_req_o     (mem_req_o),
  .mem_addr_o    (mem_addr_o),
  .mem_rvalid_i  (mem_rvalid_i),
  .fill_busy_i   (fill_busy),
  .valid_vec_i   (valid_vec)
);

// File: tb/sim_ifetch_cache.sv
`timescale 1ns/1ps
module sim_ifetch_cache;
  localparam logic [1:0] K_FETCH = 2'd0, K_CTRL = 2'd1, K_FLUSH = 2'd2;
  localparam int unsigned NV = 19;
  // {kind[1:0], req[3:0], cacheable, beats[3:0], addr[31:0]}
  localparam logic [42:0] VEC [NV] = '{
    {K_FETCH, 4'd1,  1'b1, 4'd1, 32'h0000_0100},  // R1 disabled after reset
    {K_FETCH, 4'd6,  1'b1, 4'd1, 32'h0000_0100},  // R6 no allocation
    {K_CTRL,  4'd2,  1'b0, 4'd0, 32'h0000_1000},  // R2 enable
    {K_FETCH, 4'd3,  1'b1, 4'd8, 32'h0000_0104},  // R3 fill
    {K_FETCH, 4'd4,  1'b1, 4'd0, 32'h0000_011C},  // R4 hit last word
    {K_FETCH, 4'd4,  1'b1, 4'd0, 32'h0000_0100},  // R4 hit first word
    {K_FETCH, 4'd3,  1'b1, 4'd8, 32'h0000_2104},  // R3 conflict replaces
    {K_FETCH, 4'd3,  1'b1, 4'd8, 32'h0000_0104},  // R3 refill
    {K_FETCH, 4'd7,  1'b0, 4'd1, 32'h0000_0108},  // R7 uncacheable bypass
    {K_CTRL,  4'd2,  1'b0, 4'd0, 32'hFFFF_EFFF},  // R2 disable, other bits set
    {K_FETCH, 4'd5,  1'b1, 4'd0, 32'h0000_0110},  // R5 hit while disabled
    {K_FETCH, 4'd6,  1'b1, 4'd1, 32'h0000_0400},  // R6 disabled miss
    {K_FETCH, 4'd6,  1'b1, 4'd1, 32'h0000_0400},  // R6 still not allocated
    {K_FLUSH, 4'd8,  1'b0, 4'd0, 32'h0000_0000},  // R8
    {K_FETCH, 4'd8,  1'b1, 4'd1, 32'h0000_0110},  // R8 flushed, disabled
    {K_CTRL,  4'd2,  1'b0, 4'd0, 32'h0000_1000},  // R2
    {K_FETCH, 4'd3,  1'b1, 4'd8, 32'h0000_0110},  // R3
    {K_FLUSH, 4'd8,  1'b0, 4'd0, 32'h0000_0000},  // R8
    {K_FETCH, 4'd8,  1'b1, 4'd8, 32'h0000_011C}   // R8 flushed, enabled
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ctrl_we_i = 1'b0;
  logic [31:0] ctrl_wdata_i = '0;
  logic flush_i = 1'b0, fetch_req_i = 1'b0, fetch_cacheable_i = 1'b0;
  logic [31:0] fetch_addr_i = '0;
  logic fetch_gnt_o, fetch_rvalid_o, mem_req_o;
  logic [31:0] fetch_rdata_o, mem_addr_o;
  logic mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  logic [31:0] salt = 32'h5A00_0000;
  int mem_beats = 0;
  logic [31:0] addr_log [64];
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  ifetch_cache u0 (.*);

  // memory: answers each held request after one idle cycle
  always @(negedge clk_i) begin
    if (mem_rvalid_i) mem_rvalid_i = 1'b0;
    else if (mem_req_o) begin
      mem_rvalid_i = 1'b1;
      mem_rdata_i  = mem_addr_o ^ salt;
      addr_log[mem_beats % 64] = mem_addr_o;
      mem_beats++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic ctrl_write(input logic [31:0] w);
    @(negedge clk_i); ctrl_we_i = 1'b1; ctrl_wdata_i = w;
    @(negedge clk_i); ctrl_we_i = 1'b0;
  endtask

  task automatic flush_pulse();
    @(negedge clk_i); flush_i = 1'b1;
    @(negedge clk_i); flush_i = 1'b0;
  endtask

  task automatic wait_resp(inout int lat, output logic [31:0] d);
    while (!fetch_rvalid_o && lat < 2000) begin @(negedge clk_i); lat++; end
    d = fetch_rdata_o;
  endtask

  task automatic fetch(input logic [31:0] a, input logic c, input logic fl,
                       output logic [31:0] d, output int beats, output int lat, output int b0);
    @(negedge clk_i);
    while (!fetch_gnt_o) @(negedge clk_i);
    b0 = mem_beats;
    fetch_req_i = 1'b1; fetch_addr_i = a; fetch_cacheable_i = c; flush_i = fl;
    @(negedge clk_i);
    fetch_req_i = 1'b0; flush_i = 1'b0;
    lat = 1;
    wait_resp(lat, d);
    beats = mem_beats - b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int beats, lat, b0;
    string rq;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 gnt", 32'(fetch_gnt_o), 32'd1);
    chk("R1 rvalid", 32'(fetch_rvalid_o), 32'd0);
    chk("R1 mem_req", 32'(mem_req_o), 32'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [42:0] v;
      v  = VEC[i];
      rq = $sformatf("R%0d vec%0d", v[40:37], i);
      case (v[42:41])
        K_CTRL:  ctrl_write(v[31:0]);
        K_FLUSH: flush_pulse();
        default: begin
          fetch(v[31:0], v[36], 1'b0, d, beats, lat, b0);
          chk({rq, " data"}, d, v[31:0] ^ salt);
          chk({rq, " beats"}, 32'(beats), 32'(v[35:32]));
          if (v[35:32] == 4'd0) chk({rq, " latency"}, 32'(lat), 32'd1);
          if (v[35:32] == 4'd8)
            for (int k = 0; k < 8; k++)
              chk({rq, " fill order"}, addr_log[(b0 + k) % 64],
                  {v[31:5], 5'd0} + 32'(4 * k));
          if (v[35:32] == 4'd1)
            chk({rq, " single addr"}, addr_log[b0 % 64], v[31:0]);
        end
      endcase
    end

    // R5 stale data from a hit while disabled
    fetch(32'h600, 1'b1, 1'b0, d, beats, lat, b0);
    chk("R3 fill 0x600", 32'(beats), 32'd8);
    salt = 32'h00C3_0000;
    ctrl_write(32'h0000_0000);
    fetch(32'h604, 1'b1, 1'b0, d, beats, lat, b0);
    chk("R5 stale data", d, 32'h604 ^ 32'h5A00_0000);
    chk("R5 no mem", 32'(beats), 32'd0);
    flush_pulse();
    fetch(32'h604, 1'b1, 1'b0, d, beats, lat, b0);
    chk("R8 fresh data", d, 32'h604 ^ salt);
    chk("R8 one read", 32'(beats), 32'd1);

    // R9 flush in the middle of a fill
    ctrl_write(32'h0000_1000);
    @(negedge clk_i);
    while (!fetch_gnt_o) @(negedge clk_i);
    b0 = mem_beats;
    fetch_req_i = 1'b1; fetch_addr_i = 32'h714; fetch_cacheable_i = 1'b1;
    @(negedge clk_i); fetch_req_i = 1'b0;
    while (mem_beats - b0 < 3) @(negedge clk_i);
    flush_i = 1'b1; @(negedge clk_i); flush_i = 1'b0;
    lat = 0;
    wait_resp(lat, d);
    chk("R9 data", d, 32'h714 ^ salt);
    chk("R9 beats", 32'(mem_beats - b0), 32'd8);
    fetch(32'h714, 1'b1, 1'b0, d, beats, lat, b0);
    chk("R9 line invalid", 32'(beats), 32'd8);
    fetch(32'h718, 1'b1, 1'b0, d, beats, lat, b0);
    chk("R9 refilled hit", 32'(beats), 32'd0);

    // R10 flush in the lookup cycle of a valid line
    fetch(32'h718, 1'b1, 1'b1, d, beats, lat, b0);
    chk("R10 miss", 32'(beats), 32'd8);
    chk("R10 data", d, 32'h718 ^ salt);
    fetch(32'h70C, 1'b1, 1'b0, d, beats, lat, b0);
    chk("R10 kept after", 32'(beats), 32'd0);

    // R11 grant low while memory read outstanding
    @(negedge clk_i);
    fetch_req_i = 1'b1; fetch_addr_i = 32'h900; fetch_cacheable_i = 1'b0;
    @(negedge clk_i); fetch_req_i = 1'b0;
    chk("R11 gnt busy", 32'(fetch_gnt_o), 32'd0);
    chk("R11 mem_req", 32'(mem_req_o), 32'd1);
    lat = 0;
    wait_resp(lat, d);
    chk("R7 data", d, 32'h900 ^ salt);

    // R1 reset during operation clears enable and lines
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R1 gnt in reset", 32'(fetch_gnt_o), 32'd1);
    rst_ni = 1'b1;
    fetch(32'h70C, 1'b1, 1'b0, d, beats, lat, b0);
    chk("R1 disabled single", 32'(beats), 32'd1);
    fetch(32'h70C, 1'b1, 1'b0, d, beats, lat, b0);
    chk("R1 no allocation", 32'(beats), 32'd1);

    finish_run();
  end
endmodule